// File: doc/BRIEF.md
# Banked GPIO Interrupt Controller

This block merges general-purpose pin control and interrupt collection for a parameterised set of channels (default 128), grouped into 32-bit banks (default four). Every channel owns a pad input, a pad output with its enable, and a device-side input. The device-side input is the channel's source when the pin is given to an on-chip peripheral. A small configuration word per channel picks who owns the pin, how an event is recognised, and which of four CPU request lines the channel feeds.

Software works through a 32-bit register bus with address, write enable, write data, read enable and registered read data. Pin levels, pending flags and enables each have one address to set bits and one address to clear bits. A priority register returns the lowest-numbered channel that is both pending and enabled. This lets a handler find its next source with a single read, then acknowledge it by clearing its pending bit.

Top module: `gpic_top`

## Requirements
- R1: After reset all enables, pending flags and configuration words are zero, every pad output enable is low, all four request lines are low and the priority register reads 127.
- R2: Channel n lives in bank n>>5 at bit n%32. A read of byte address 0x00+4·bank or 0x10+4·bank returns the current level of that bank's channels: the synchronised pad for a pin in modes 0, 2 or 3, and the device input for a pin in mode 1.
- R3: Writing 1s to 0x00+4·bank puts those channels into drive-high mode (pin field 3, output enable high, pad out 1). Writing 1s to 0x10+4·bank puts them into drive-low mode (pin field 2, output enable high, pad out 0). These writes work whatever the enable bit is. Pin field 0 (input) and 1 (device) keep the output enable low.
- R4: Pending flags read at 0x20+4·bank. Writing 1s there clears those flags, and 0 bits leave flags alone.
- R5: Writing 1s to 0x40+4·bank sets enable bits. Writing 1s to 0x50+4·bank clears them. Both addresses read back the enable bits.
- R6: The configuration word of channel N is at 0x1000+4·N, in read bits [7:0]. Bits [1:0] hold the pin mode, [3:2] the request line, [6:4] the trigger code and [7] a stored wake flag. A write to it is ignored while channel N's enable bit is set.
- R7: Trigger code 1 (low level) and code 2 (high level) set pending on every cycle the level is active. If the level persists, pending stays set even through a clear write.
- R8: Trigger code 5 (falling), code 6 (rising) and code 7 (either edge) set pending once per matching transition. Codes 0, 3 and 4 never set pending.
- R9: Request line L is high when at least one channel routed to L is both pending and enabled.
- R10: A read of 0x30 returns the lowest-numbered channel that is pending and enabled, or 127 when there is none.
- R11: A pad change becomes a pending flag on the third rising clock edge after it, because of a two-flop synchroniser and the pending register. A device-input change becomes a pending flag on the first edge. Read data appears on the clock edge after the read enable and holds until the next read.

Top module ports appear in the order below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | 13 | Byte address |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| pad_i | input | 128 | Pad input levels |
| dev_i | input | 128 | Device-side inputs |
| pad_out_o | output | 128 | Pad output values |
| pad_oe_o | output | 128 | Pad output enables |
| irq_o | output | 4 | CPU interrupt request lines |

## Verification
On every cycle the assertions check these points:
- The request lines and the priority result agree on whether any work is waiting.
- The reported channel is really pending and enabled.
- A set-enable write lands.
- A configuration write to a locked channel leaves its word unchanged.
- Output enables move only after a bus write.

Only the bench's scenarios can show the rest. These include the exact latency of pad and device events, level re-assertion after a clear, the lowest-index choice among several sources, the disabled trigger codes, and the routing of each channel to its chosen line.

// File: rtl/gpic_pkg.sv
package gpic_pkg;

    typedef enum logic [1:0] {
        PIN_IN   = 2'd0,
        PIN_DEV  = 2'd1,
        PIN_DRV0 = 2'd2,
        PIN_DRV1 = 2'd3
    } pin_mode_e;

    typedef enum logic [2:0] {
        TRG_OFF  = 3'd0,
        TRG_LOW  = 3'd1,
        TRG_HIGH = 3'd2,
        TRG_RSV3 = 3'd3,
        TRG_RSV4 = 3'd4,
        TRG_FALL = 3'd5,
        TRG_RISE = 3'd6,
        TRG_ANY  = 3'd7
    } trig_e;

    typedef struct packed {
        logic      wake;
        trig_e     trig;
        logic [1:0] line;
        pin_mode_e pin;
    } chan_cfg_t;

    // register groups in the low region, 16 bytes apart, one word per bank
    localparam logic [3:0] GRP_PSET = 4'd0;
    localparam logic [3:0] GRP_PCLR = 4'd1;
    localparam logic [3:0] GRP_PEND = 4'd2;
    localparam logic [3:0] GRP_PRIO = 4'd3;
    localparam logic [3:0] GRP_MSET = 4'd4;
    localparam logic [3:0] GRP_MCLR = 4'd5;

endpackage

// File: rtl/gpic_chan.sv
module gpic_chan
    import gpic_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      pad_i,
    input  logic      dev_i,
    input  pin_mode_e pin_i,
    input  trig_e     trig_i,
    output logic      level_o,
    output logic      hit_o
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        level_o   = (pin_i == PIN_DEV) ? dev_i : st_q.s2;
        st_d.s1   = pad_i;
        st_d.s2   = st_q.s1;
        st_d.prev = level_o;
        case (trig_i)
            TRG_LOW:  hit_o = !level_o;
            TRG_HIGH: hit_o = level_o;
            TRG_FALL: hit_o = st_q.prev && !level_o;
            TRG_RISE: hit_o = !st_q.prev && level_o;
            TRG_ANY:  hit_o = st_q.prev ^ level_o;
            default:  hit_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/gpic_prio.sv
module gpic_prio #(
    parameter int NUM_CH = 128,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              valid_o
);

    always_comb begin
        valid_o = 1'b0;
        idx_o   = '1;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/gpic_top.sv
module gpic_top
    import gpic_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int DATA_W    = 32,
    parameter int NUM_LINES = 4,
    parameter int ADDR_W    = 13,
    localparam int BANK_W   = DATA_W,
    localparam int NUM_CH   = NUM_BANKS * BANK_W,
    localparam int IDX_W    = $clog2(NUM_CH),
    localparam int CFG_BIT  = ADDR_W - 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [NUM_CH-1:0] pad_i,
    input  logic [NUM_CH-1:0] dev_i,
    output logic [NUM_CH-1:0] pad_out_o,
    output logic [NUM_CH-1:0] pad_oe_o,
    output logic [NUM_LINES-1:0] irq_o
);

    typedef struct packed {
        chan_cfg_t [NUM_CH-1:0] cfg;
        logic [NUM_CH-1:0]      mask;
        logic [NUM_CH-1:0]      pend;
        logic [DATA_W-1:0]      rdata;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_CH-1:0] level, hit;
    logic [IDX_W-1:0]  prio_idx;
    logic              prio_valid;
    logic [NUM_CH-1:0] mask_q, pend_q;
    chan_cfg_t         cfg0_q;

    // address decode
    logic [3:0]        grp;
    logic [1:0]        bank;
    logic              lo_hit, cfg_hit, lo_wr, cfg_wr;
    logic [IDX_W-1:0]  cfg_idx;
    logic [NUM_CH-1:0] wvec;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_abits;

    assign grp          = addr_i[7:4];
    assign bank         = addr_i[3:2];
    assign lo_hit       = !addr_i[CFG_BIT] && (addr_i[CFG_BIT-1:8] == '0);
    assign cfg_hit      = addr_i[CFG_BIT] && (int'(addr_i[CFG_BIT-1:2]) < NUM_CH);
    assign cfg_idx      = addr_i[2 +: IDX_W];
    assign lo_wr        = wr_en_i && lo_hit;
    assign cfg_wr       = wr_en_i && cfg_hit;
    assign unused_abits = ^addr_i[1:0];

    // per-channel synchroniser and trigger detector
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        gpic_chan u_ch (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .pad_i  (pad_i[g]),
            .dev_i  (dev_i[g]),
            .pin_i  (st_q.cfg[g].pin),
            .trig_i (st_q.cfg[g].trig),
            .level_o(level[g]),
            .hit_o  (hit[g])
        );
        assign pad_oe_o[g]  = st_q.cfg[g].pin[1];
        assign pad_out_o[g] = (st_q.cfg[g].pin == PIN_DRV1);
    end

    gpic_prio #(.NUM_CH(NUM_CH)) u_prio (
        .req_i  (st_q.pend & st_q.mask),
        .idx_o  (prio_idx),
        .valid_o(prio_valid)
    );

    // read multiplexer
    always_comb begin
        rd_mux = '0;
        if (cfg_hit) begin
            rd_mux = DATA_W'(st_q.cfg[cfg_idx]);
        end else if (lo_hit && int'(bank) < NUM_BANKS) begin
            case (grp)
                GRP_PSET, GRP_PCLR: rd_mux = level[int'(bank)*BANK_W +: BANK_W];
                GRP_PEND:           rd_mux = st_q.pend[int'(bank)*BANK_W +: BANK_W];
                GRP_PRIO:           rd_mux = DATA_W'(prio_idx);
                GRP_MSET, GRP_MCLR: rd_mux = st_q.mask[int'(bank)*BANK_W +: BANK_W];
                default:            rd_mux = '0;
            endcase
        end
    end

    // next-state computation
    always_comb begin
        st_d = st_q;
        wvec = '0;
        if (int'(bank) < NUM_BANKS) wvec[int'(bank)*BANK_W +: BANK_W] = wr_data_i;

        st_d.pend = (st_q.pend & ~((lo_wr && grp == GRP_PEND) ? wvec : '0)) | hit;

        if (lo_wr && grp == GRP_MSET) st_d.mask = st_q.mask | wvec;
        if (lo_wr && grp == GRP_MCLR) st_d.mask = st_q.mask & ~wvec;

        for (int i = 0; i < NUM_CH; i++) begin
            if (lo_wr && grp == GRP_PSET && wvec[i]) st_d.cfg[i].pin = PIN_DRV1;
            if (lo_wr && grp == GRP_PCLR && wvec[i]) st_d.cfg[i].pin = PIN_DRV0;
        end

        if (cfg_wr && !st_q.mask[cfg_idx]) st_d.cfg[cfg_idx] = chan_cfg_t'(wr_data_i[7:0]);

        if (rd_en_i) st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // request lines
    always_comb begin
        irq_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (st_q.pend[i] && st_q.mask[i]) irq_o[st_q.cfg[i].line] = 1'b1;
        end
    end

    assign rd_data_o = st_q.rdata;
    assign mask_q    = st_q.mask;
    assign pend_q    = st_q.pend;
    assign cfg0_q    = st_q.cfg[0];

endmodule

// File: rtl/gpic_chk.sv
module gpic_chk #(
    parameter int NUM_CH    = 128,
    parameter int NUM_LINES = 4,
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_CH)
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 wr_en_i,
    input logic [ADDR_W-1:0]    addr_i,
    input logic [DATA_W-1:0]    wr_data_i,
    input logic [NUM_LINES-1:0] irq_i,
    input logic [NUM_CH-1:0]    pad_oe_i,
    input logic [NUM_CH-1:0]    mask_i,
    input logic [NUM_CH-1:0]    pend_i,
    input logic [7:0]           cfg0_i,
    input logic [IDX_W-1:0]     prio_idx_i,
    input logic                 prio_valid_i
);

    localparam logic [ADDR_W-1:0] MSET0 = ADDR_W'(16'h0040);
    localparam logic [ADDR_W-1:0] CFG0  = ADDR_W'(1) << (ADDR_W - 1);

    AST_IRQ_AGREES_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|irq_i) == prio_valid_i); // R9

    AST_PRIO_QUALIFIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        prio_valid_i |-> (pend_i[prio_idx_i] && mask_i[prio_idx_i])); // R10

    AST_MASK_SET_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == MSET0) |=> ((mask_i[DATA_W-1:0] & $past(wr_data_i)) == $past(wr_data_i))); // R5

    AST_CFG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == CFG0 && mask_i[0]) |=> $stable(cfg0_i)); // R6

    AST_OE_BY_BUS_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(pad_oe_i) |-> $past(wr_en_i)); // R3

endmodule

bind gpic_top gpic_chk #(
    .NUM_CH(NUM_CH), .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wr_data_i   (wr_data_i),
    .irq_i       (irq_o),
    .pad_oe_i    (pad_oe_o),
    .mask_i      (mask_q),
    .pend_i      (pend_q),
    .cfg0_i      (cfg0_q),
    .prio_idx_i  (prio_idx),
    .prio_valid_i(prio_valid)
);

// File: tb/tb_gpic_top.sv
module tb_gpic_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [12:0]  addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rd_data;
    logic [127:0] pad = '0, dev = '0;
    logic [127:0] pad_out, pad_oe;
    logic [3:0]   irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    gpic_top dut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rd_data),
        .pad_i(pad), .dev_i(dev), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
        .irq_o(irq)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [127:0] m_s1, m_s2, m_prev, m_pend, m_mask;
    logic [7:0]   m_cfg [128];
    logic [31:0]  m_rd;

    always @(posedge clk) begin : model
        logic [127:0] lv, hit, wv, clr, e_oe, e_out;
        logic [31:0]  rv;
        logic [3:0]   e_irq;
        int grp, bk, ch, p;
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0; m_mask = '0; m_rd = '0;
            for (int i = 0; i < 128; i++) m_cfg[i] = '0;
        end else begin
            for (int i = 0; i < 128; i++) begin
                lv[i] = (m_cfg[i][1:0] == 2'd1) ? dev[i] : m_s2[i];
                case (m_cfg[i][6:4])
                    3'd1: hit[i] = !lv[i];
                    3'd2: hit[i] = lv[i];
                    3'd5: hit[i] = m_prev[i] && !lv[i];
                    3'd6: hit[i] = !m_prev[i] && lv[i];
                    3'd7: hit[i] = m_prev[i] != lv[i];
                    default: hit[i] = 1'b0;
                endcase
            end
            p = 127;
            for (int i = 127; i >= 0; i--) if (m_pend[i] && m_mask[i]) p = i;
            grp = int'(addr) / 16;
            bk  = (int'(addr) % 16) / 4;
            ch  = (int'(addr) - 4096) / 4;
            wv  = 128'(wdata) << (bk * 32);
            rv  = '0;
            if (addr >= 13'h1000) begin
                if (ch < 128) rv = {24'b0, m_cfg[ch]};
            end else if (addr < 13'h100) begin
                case (grp)
                    0, 1: rv = lv[bk*32 +: 32];
                    2:    rv = m_pend[bk*32 +: 32];
                    3:    rv = p;
                    4, 5: rv = m_mask[bk*32 +: 32];
                    default: rv = '0;
                endcase
            end
            if (rd_en) m_rd = rv;
            clr = '0;
            if (wr_en) begin
                if (addr >= 13'h1000) begin
                    if (ch < 128 && !m_mask[ch]) m_cfg[ch] = wdata[7:0];
                end else if (addr < 13'h100) begin
                    for (int i = 0; i < 128; i++) begin
                        if (grp == 0 && wv[i]) m_cfg[i][1:0] = 2'd3;
                        if (grp == 1 && wv[i]) m_cfg[i][1:0] = 2'd2;
                    end
                    if (grp == 2) clr = wv;
                    if (grp == 4) m_mask = m_mask | wv;
                    if (grp == 5) m_mask = m_mask & ~wv;
                end
            end
            m_pend = (m_pend & ~clr) | hit;
            m_prev = lv;
            m_s2   = m_s1;
            m_s1   = pad;
        end
        #1;
        if (rst_n && !done) begin
            e_irq = '0;
            for (int i = 0; i < 128; i++) begin
                if (m_pend[i] && m_mask[i]) e_irq[m_cfg[i][3:2]] = 1'b1;
                e_oe[i]  = m_cfg[i][1];
                e_out[i] = (m_cfg[i][1:0] == 2'd3);
            end
            check("R9 model irq", 128'(irq), 128'(e_irq));
            check("R3 model pad_oe", pad_oe, e_oe);
            check("R3 model pad_out", pad_out, e_out);
            check("R10 model rd_data", 128'(rd_data), 128'(m_rd));
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0; d = rd_data;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        waitc(3);
        @(negedge clk); rst_n = 1'b1;
        waitc(1);

        // R1 reset state
        check("R1 pad_oe", pad_oe, '0);
        check("R1 irq", 128'(irq), '0);
        rd(13'h030, d); check("R1 prio none", 128'(d), 127);
        rd(13'h040, d); check("R1 mask", 128'(d), 0);
        rd(13'h1014, d); check("R1 cfg5", 128'(d), 0);

        // R3 drive high / low on channel 35
        wr(13'h004, 32'h8);
        check("R3 oe35", 128'(pad_oe[35]), 1);
        check("R3 out35 high", 128'(pad_out[35]), 1);
        rd(13'h108C, d); check("R3 cfg35 drv1", 128'(d), 3);
        wr(13'h014, 32'h8);
        check("R3 out35 low", 128'(pad_out[35]), 0);
        rd(13'h108C, d); check("R3 cfg35 drv0", 128'(d), 2);

        // R2 pin level read for channel 70 (bank 2 bit 6)
        @(negedge clk); pad[70] = 1'b1;
        waitc(3);
        rd(13'h008, d); check("R2 bank2 level", 128'(d), 32'h40);

        // R8 rising edge on channel 70, line 1
        wr(13'h1118, 32'h64);
        wr(13'h048, 32'h40);
        @(negedge clk); pad[70] = 1'b0;
        waitc(5);
        rd(13'h028, d); check("R8 no pend on fall", 128'(d), 0);
        @(negedge clk); pad[70] = 1'b1;
        waitc(5);
        rd(13'h028, d); check("R8 rise pend", 128'(d), 32'h40);
        check("R9 line1", 128'(irq), 4'b0010);
        rd(13'h030, d); check("R10 prio 70", 128'(d), 70);
        wr(13'h028, 32'h40);
        rd(13'h028, d); check("R4 w1c clears", 128'(d), 0);
        check("R9 line1 low", 128'(irq), 0);

        // R6 configuration lock
        wr(13'h1118, 32'h0);
        rd(13'h1118, d); check("R6 locked write ignored", 128'(d), 32'h64);
        wr(13'h058, 32'h40);
        rd(13'h048, d); check("R5 mask cleared", 128'(d), 0);
        wr(13'h1118, 32'h0);
        rd(13'h1118, d); check("R6 unlocked write", 128'(d), 0);

        // R7 / R11 high level from device input on channel 2, line 3
        wr(13'h1008, 32'h2D);
        wr(13'h040, 32'h4);
        check("R11 device pin released", 128'(pad_oe[2]), 0);
        @(negedge clk); dev[2] = 1'b1;
        @(negedge clk);
        check("R11 device one edge", 128'(irq), 4'b1000);
        rd(13'h020, d); check("R7 level pend", 128'(d), 32'h4);
        wr(13'h020, 32'h4);
        rd(13'h020, d); check("R7 reasserts", 128'(d), 32'h4);
        @(negedge clk); dev[2] = 1'b0;
        waitc(2);
        wr(13'h020, 32'h4);
        rd(13'h020, d); check("R7 clear after release", 128'(d), 0);

        // R10 lowest index wins; low level on channel 9, line 0
        @(negedge clk); dev[2] = 1'b1;
        wr(13'h1024, 32'h10);
        wr(13'h040, 32'h204);
        waitc(2);
        rd(13'h030, d); check("R10 lowest is 2", 128'(d), 2);
        wr(13'h050, 32'h4);
        rd(13'h030, d); check("R10 next is 9", 128'(d), 9);
        rd(13'h050, d); check("R5 read at clear addr", 128'(d), 32'h200);
        check("R9 line0 only", 128'(irq), 4'b0001);
        @(negedge clk); pad[9] = 1'b1; dev[2] = 1'b0;
        waitc(4);
        wr(13'h020, 32'h204);
        rd(13'h030, d); check("R10 none", 128'(d), 127);

        // R8 reserved, any-change and falling codes in bank 3
        wr(13'h1190, 32'h30);
        wr(13'h1194, 32'h70);
        wr(13'h1198, 32'h50);
        wr(13'h04C, 32'h70);
        rd(13'h05C, d); check("R5 bank3 mask", 128'(d), 32'h70);
        @(negedge clk); pad[100] = 1'b1; pad[101] = 1'b1; pad[102] = 1'b1;
        waitc(5);
        rd(13'h02C, d); check("R8 rise: any only", 128'(d), 32'h20);
        rd(13'h00C, d); check("R2 bank3 level", 128'(d), 32'h70);
        wr(13'h02C, 32'h70);
        @(negedge clk); pad[100] = 1'b0; pad[101] = 1'b0; pad[102] = 1'b0;
        waitc(5);
        rd(13'h02C, d); check("R8 fall: any and falling", 128'(d), 32'h60);
        wr(13'h02C, 32'h70);

        // R11 pad latency on channel 101 (line 0)
        @(negedge clk); pad[101] = 1'b1;
        @(negedge clk); check("R11 pad after 1 edge", 128'(irq), 0);
        @(negedge clk); check("R11 pad after 2 edges", 128'(irq), 0);
        @(negedge clk); check("R11 pad after 3 edges", 128'(irq), 4'b0001);
        rd(13'h030, d); check("R11 prio 101", 128'(d), 101);
        wr(13'h02C, 32'h20);
        check("R11 read data held", 128'(rd_data), 101);

        waitc(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule